// File: doc/BRIEF.md
# Variable-Length Instruction Length Decoder

This front-end block takes a stream of 32-bit aligned fetch words. Each word holds two 16-bit parcels, and the block turns that stream into whole instructions of one, two or three parcels. The top two bits of an instruction's first parcel give its length. Instructions may start on any parcel, so one instruction can begin in one fetch word and end in the next. A small circular parcel buffer absorbs this misalignment. The block then emits at most one complete instruction per cycle on a registered output with a valid/ready handshake.

The block also tracks a parcel-granular instruction address. It advances that address by each emitted instruction's length. A redirect reloads the address from a target, drops everything buffered or pending, and prepares to discard the lower parcel of the first fetch word when the target is odd. The block does no decoding beyond the length field.

Top module: `vl_len_decoder`

## Requirements
- R1: After reset `insn_valid` is 0 and `fetch_ready` is 1.
- R2: The length comes from bits [15:14] of the first parcel. 00 gives one parcel (16 bits), 01 and 10 give two parcels (32 bits), and 11 gives three parcels (48 bits). `insn_len` reports the parcel count as 1, 2 or 3.
- R3: Within a fetch word, bits [15:0] are the lower-addressed parcel. In `insn_data` the first parcel sits in [15:0], the second in [31:16] and the third in [47:32]. Parcel slots the instruction does not use read as zero.
- R4: Each emitted instruction's address equals the previous one's address plus its parcel count.
- R5: An instruction whose parcels span two fetch words is emitted whole and in order, under any mix of lengths.
- R6: A redirect drops any pending output in the next cycle and flushes the buffer. Fetch words offered in the redirect cycle are ignored. The first instruction afterwards carries the target address.
- R7: When the redirect target is odd, the lower parcel of the first accepted fetch word is discarded.
- R8: While `insn_valid` is 1 and `insn_ready` is 0, the output's data, length and address hold unchanged.
- R9: The buffer holds DEPTH parcels (6 by default). `fetch_ready` is 0 when fewer than two slots are free, and the buffer never overflows. With the output stalled from an empty state and only 48-bit instructions arriving, exactly four fetch words are accepted.
- R10: An instruction completed by a fetch word accepted at clock edge k appears at the output after edge k+1, when the output is free. Two instructions from one word are emitted on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch word is offered |
| fetch_data | input | 2*PW | Fetch word; [15:0] is the lower-addressed parcel |
| fetch_ready | output | 1 | Buffer can take a whole fetch word |
| redir_valid | input | 1 | Reload address and flush |
| redir_addr | input | AW | Parcel-granular target address |
| insn_valid | output | 1 | Output instruction is valid |
| insn_data | output | 3*PW | Instruction parcels, first parcel lowest, zero-filled |
| insn_len | output | 2 | Parcel count 1..3 |
| insn_addr | output | AW | Parcel address of the instruction |
| insn_ready | input | 1 | Consumer takes the instruction |

## Verification
The main function is driven with several kinds of program. A run of only 16-bit instructions checks basic ordering and address stepping. A repeating mix of all three lengths forces every alignment of start parcel against fetch word, so it separates correct spanning from a decoder that assumes alignment. A run of only 48-bit instructions starting at an odd parcel checks that the dropped low parcel does not pose as a 48-bit header. A stall pattern on `insn_ready` and a fully stalled output check output holding and the exact fill point of the buffer. A redirect issued while an instruction is pending checks that stale instructions never leak out.

// File: rtl/vld_pkg.sv
package vld_pkg;
  // parcel count of one instruction; zero means "no instruction"
  typedef enum logic [1:0] {
    PLEN_NONE = 2'd0,
    PLEN_ONE  = 2'd1,
    PLEN_TWO  = 2'd2,
    PLEN_THREE = 2'd3
  } plen_e;

  localparam int unsigned MAX_PARCELS = 3;

  function automatic plen_e code_to_plen(input logic [1:0] code);
    case (code)
      2'b00:   return PLEN_ONE;
      2'b11:   return PLEN_THREE;
      default: return PLEN_TWO;
    endcase
  endfunction
endpackage

// File: rtl/vld_parcel_buf.sv
module vld_parcel_buf #(
  parameter int unsigned PW    = 16,
  parameter int unsigned DEPTH = 6,
  parameter int unsigned MAXP  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic [1:0]              push_n,
  input  logic [PW-1:0]           in_a,
  input  logic [PW-1:0]           in_b,
  input  logic [1:0]              pop_n,
  output logic [MAXP-1:0][PW-1:0] heads,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                    room_two
);
  localparam int unsigned PTRW = $clog2(DEPTH);
  localparam int unsigned CW   = $clog2(DEPTH+1);

  logic [PW-1:0]   mem [DEPTH];
  logic [PTRW-1:0] rd_q, wr_q;
  logic [CW-1:0]   cnt_q;

  function automatic logic [PTRW-1:0] adv(input logic [PTRW-1:0] p, input int unsigned k);
    int unsigned s;
    s = int'(p) + k;
    if (s >= DEPTH) s = s - DEPTH;
    return PTRW'(s);
  endfunction

  assign count    = cnt_q;
  assign room_two = (CW'(DEPTH) - cnt_q) >= CW'(2);

  for (genvar g = 0; g < MAXP; g++) begin : g_head
    assign heads[g] = mem[adv(rd_q, g)];
  end

  always_ff @(posedge clk) begin
    if (!flush && push_n != 2'd0) mem[wr_q] <= in_a;
    if (!flush && push_n == 2'd2) mem[adv(wr_q, 1)] <= in_b;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= adv(rd_q, int'(pop_n));
      wr_q  <= adv(wr_q, int'(push_n));
      cnt_q <= cnt_q + CW'(push_n) - CW'(pop_n);
    end
  end

  // R9: a push never exceeds the free space
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    !flush |-> (int'(cnt_q) + int'(push_n)) <= int'(DEPTH));
  // R9: a producer only writes when at least two slots are free
  p_stall_when_full_r9: assert property (@(posedge clk) disable iff (rst)
    ((int'(DEPTH) - int'(cnt_q)) < 2) |-> push_n == 2'd0);
  // R5: never pop parcels that are not there
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    int'(pop_n) <= int'(cnt_q));
endmodule

// File: rtl/vld_len_decode.sv
module vld_len_decode
  import vld_pkg::*;
#(
  parameter int unsigned PW = 16,
  parameter int unsigned CW = 3
) (
  input  logic [PW-1:0] head0,
  input  logic [CW-1:0] count,
  output plen_e         need,
  output logic          complete
);
  assign need     = code_to_plen(head0[PW-1:PW-2]);
  assign complete = (count != '0) && (count >= CW'(need));
endmodule

// File: rtl/vld_out_stage.sv
module vld_out_stage
  import vld_pkg::*;
#(
  parameter int unsigned PW   = 16,
  parameter int unsigned AW   = 32,
  parameter int unsigned MAXP = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    redir,
  input  logic [AW-1:0]           redir_addr,
  input  logic                    complete,
  input  plen_e                   need,
  input  logic [MAXP-1:0][PW-1:0] heads,
  input  logic                    out_ready,
  output logic [1:0]              pop_n,
  output logic                    out_valid,
  output logic [MAXP*PW-1:0]      out_data,
  output logic [1:0]              out_len,
  output logic [AW-1:0]           out_addr
);
  logic [MAXP*PW-1:0] packed_d;
  logic [AW-1:0]      pc_q;
  logic               load;

  for (genvar g = 0; g < MAXP; g++) begin : g_slot
    assign packed_d[g*PW +: PW] = (g < int'(need)) ? heads[g] : '0;
  end

  assign load  = complete && (!out_valid || out_ready) && !redir;
  assign pop_n = load ? 2'(need) : 2'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_len   <= 2'd0;
      out_addr  <= '0;
      pc_q      <= '0;
    end else if (redir) begin
      out_valid <= 1'b0;
      pc_q      <= redir_addr;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= packed_d;
      out_len   <= 2'(need);
      out_addr  <= pc_q;
      pc_q      <= pc_q + AW'(need);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: a stalled instruction holds
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && !redir |=>
      out_valid && $stable(out_data) && $stable(out_addr) && $stable(out_len));
  // R4: consecutive instructions are contiguous
  p_next_addr_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !redir |=>
      !out_valid || out_addr == $past(out_addr) + AW'($past(out_len)));
  // R6: a redirect drops the pending instruction
  p_flush_r6: assert property (@(posedge clk) disable iff (rst)
    redir |=> !out_valid);
endmodule

// File: rtl/vl_len_decoder.sv
module vl_len_decoder
  import vld_pkg::*;
#(
  parameter int unsigned PW    = 16,
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fetch_valid,
  input  logic [2*PW-1:0]       fetch_data,
  output logic                  fetch_ready,
  input  logic                  redir_valid,
  input  logic [AW-1:0]         redir_addr,
  output logic                  insn_valid,
  output logic [MAX_PARCELS*PW-1:0] insn_data,
  output logic [1:0]            insn_len,
  output logic [AW-1:0]         insn_addr,
  input  logic                  insn_ready
);
  localparam int unsigned MAXP = MAX_PARCELS;
  localparam int unsigned CW   = $clog2(DEPTH+1);

  logic                    skip_low_q;
  logic                    take;
  logic [1:0]              push_n, pop_n;
  logic [PW-1:0]           in_a, in_b;
  logic [MAXP-1:0][PW-1:0] heads;
  logic [CW-1:0]           count;
  logic                    room_two;
  plen_e                   need;
  logic                    complete;

  assign fetch_ready = room_two;
  assign take   = fetch_valid && room_two && !redir_valid;
  assign push_n = take ? (skip_low_q ? 2'd1 : 2'd2) : 2'd0;
  assign in_a   = skip_low_q ? fetch_data[2*PW-1:PW] : fetch_data[PW-1:0];
  assign in_b   = fetch_data[2*PW-1:PW];

  always_ff @(posedge clk) begin
    if (rst)              skip_low_q <= 1'b0;
    else if (redir_valid) skip_low_q <= redir_addr[0];
    else if (take)        skip_low_q <= 1'b0;
  end

  vld_parcel_buf #(.PW(PW), .DEPTH(DEPTH), .MAXP(MAXP)) buf_i (
    .clk(clk), .rst(rst), .flush(redir_valid),
    .push_n(push_n), .in_a(in_a), .in_b(in_b), .pop_n(pop_n),
    .heads(heads), .count(count), .room_two(room_two)
  );

  vld_len_decode #(.PW(PW), .CW(CW)) len_i (
    .head0(heads[0]), .count(count), .need(need), .complete(complete)
  );

  vld_out_stage #(.PW(PW), .AW(AW), .MAXP(MAXP)) out_i (
    .clk(clk), .rst(rst), .redir(redir_valid), .redir_addr(redir_addr),
    .complete(complete), .need(need), .heads(heads), .out_ready(insn_ready),
    .pop_n(pop_n), .out_valid(insn_valid), .out_data(insn_data),
    .out_len(insn_len), .out_addr(insn_addr)
  );

  // R2: reported length agrees with the header bits of the output
  p_len_code_r2: assert property (@(posedge clk) disable iff (rst)
    insn_valid |-> insn_len == ((insn_data[PW-1:PW-2] == 2'b00) ? 2'd1 :
                                (insn_data[PW-1:PW-2] == 2'b11) ? 2'd3 : 2'd2));
  // R3: unused parcel slots are zero
  p_zero_fill_r3: assert property (@(posedge clk) disable iff (rst)
    insn_valid && insn_len == 2'd1 |-> insn_data[MAXP*PW-1:PW] == '0);
  // R1: idle state straight after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> !insn_valid && fetch_ready);
endmodule

// File: tb/vl_len_decoder_tb_top.sv
`timescale 1ns/1ps
module vl_len_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_data = '0;
  logic        fetch_ready;
  logic        redir_valid = 1'b0;
  logic [31:0] redir_addr = '0;
  logic        insn_valid;
  logic [47:0] insn_data;
  logic [1:0]  insn_len;
  logic [31:0] insn_addr;
  logic        insn_ready = 1'b0;

  always #2.5 clk = ~clk;

  vl_len_decoder dut_i (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .fetch_ready(fetch_ready), .redir_valid(redir_valid), .redir_addr(redir_addr),
    .insn_valid(insn_valid), .insn_data(insn_data), .insn_len(insn_len),
    .insn_addr(insn_addr), .insn_ready(insn_ready)
  );

  int total = 0;
  int bad = 0;
  int bp_mode = 0;
  int cyc = 0;
  int got = 0;
  int exp_n = 0;
  int n_acc = 0;
  int nw = 0;
  string cur_req = "R2";
  logic [47:0] exp_d [0:511];
  logic [1:0]  exp_l [0:511];
  logic [31:0] exp_a [0:511];
  logic [15:0] pbuf [0:1023];
  logic [31:0] wbuf [0:511];
  logic        h_pend = 1'b0;
  logic [47:0] h_d;
  logic [31:0] h_a;
  logic [1:0]  h_l;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic int lenof(input int kind, input int i);
    int pat [12] = '{1, 2, 3, 3, 2, 1, 2, 3, 1, 1, 3, 2};
    if (kind == 0) return 1;
    if (kind == 2) return 3;
    return pat[i % 12];
  endfunction

  // monitor: drives insn_ready and compares each handshake
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      insn_ready = (bp_mode == 0) ? 1'b1 : (bp_mode == 1) ? ((cyc % 3) == 0) : 1'b0;
      if (h_pend)
        chk(insn_valid && insn_data == h_d && insn_addr == h_a && insn_len == h_l,
            "R8", "held output", {insn_addr, insn_data[31:0]}, {h_a, h_d[31:0]});
      h_pend = insn_valid && !insn_ready && !redir_valid;
      h_d = insn_data; h_a = insn_addr; h_l = insn_len;
      if (insn_valid && insn_ready) begin
        if (got < exp_n)
          chk(insn_data == exp_d[got] && insn_len == exp_l[got] && insn_addr == exp_a[got],
              cur_req, "instruction", {insn_addr[13:0], insn_len, insn_data},
              {exp_a[got][13:0], exp_l[got], exp_d[got]});
        else
          chk(1'b0, cur_req, "unexpected instruction", {insn_addr, 32'h0}, 64'h0);
        got++;
      end
    end
  end

  task automatic build(input logic [31:0] start, input int kind, input int n);
    int np = 0;
    logic [31:0] a = start;
    exp_n = 0; got = 0;
    if (start[0]) begin pbuf[np] = 16'hFFFF; np++; end
    for (int i = 0; i < n; i++) begin
      int L = lenof(kind, i);
      logic [1:0] code;
      logic [15:0] p0, p1, p2;
      code = (L == 1) ? 2'b00 : (L == 3) ? 2'b11 : (i % 2 == 1) ? 2'b01 : 2'b10;
      p0 = {code, 14'(i * 37 + int'(start[13:0]))};
      p1 = 16'(i * 1237 + 16'h5A5A);
      p2 = 16'(i * 911 + 16'hC3C3);
      pbuf[np] = p0; np++;
      if (L > 1) begin pbuf[np] = p1; np++; end
      if (L > 2) begin pbuf[np] = p2; np++; end
      exp_d[exp_n] = {(L > 2) ? p2 : 16'h0, (L > 1) ? p1 : 16'h0, p0};
      exp_l[exp_n] = 2'(L);
      exp_a[exp_n] = a;
      a = a + 32'(L);
      exp_n++;
    end
    if (np % 2 == 1) begin pbuf[np] = 16'hFFFF; np++; end
    nw = np / 2;
    for (int k = 0; k < nw; k++) wbuf[k] = {pbuf[2*k+1], pbuf[2*k]};
  endtask

  task automatic redirect(input logic [31:0] a);
    redir_valid = 1'b1; redir_addr = a;
    @(posedge clk); #1;
    redir_valid = 1'b0;
  endtask

  task automatic push_word(input logic [31:0] w);
    bit ok;
    fetch_valid = 1'b1; fetch_data = w;
    do begin
      @(negedge clk); ok = fetch_ready;
      @(posedge clk); #1;
    end while (!ok);
    n_acc++;
    fetch_valid = 1'b0;
  endtask

  task automatic push_all();
    for (int k = 0; k < nw; k++) push_word(wbuf[k]);
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (got < exp_n && t < 3000) begin @(posedge clk); #1; t++; end
    repeat (6) @(posedge clk);
    #1;
    chk(got == exp_n, req, "instruction count", 64'(got), 64'(exp_n));
  endtask

  task automatic run_prog(input logic [31:0] start, input int kind, input int n,
                          input int mode, input string req);
    bp_mode = mode; cur_req = req;
    build(start, kind, n);
    redirect(start);
    push_all();
    wait_done(req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!insn_valid, "R1", "insn_valid after reset", 64'(insn_valid), 64'd0);
    chk(fetch_ready, "R1", "fetch_ready after reset", 64'(fetch_ready), 64'd1);
    @(posedge clk); #1;
  endtask

  task automatic t_latency();
    bp_mode = 0; cur_req = "R10";
    build(32'h300, 0, 2);
    redirect(32'h300);
    push_word(wbuf[0]);
    @(negedge clk);
    chk(!insn_valid, "R10", "valid one cycle early", 64'(insn_valid), 64'd0);
    @(negedge clk);
    chk(insn_valid && insn_addr == 32'h300, "R10", "first of pair", 64'(insn_addr), 64'h300);
    @(negedge clk);
    chk(insn_valid && insn_addr == 32'h301, "R10", "second of pair", 64'(insn_addr), 64'h301);
    @(posedge clk); #1;
    wait_done("R10");
  endtask

  task automatic t_fill();
    bp_mode = 2; cur_req = "R9";
    build(32'h800, 2, 6);
    redirect(32'h800);
    n_acc = 0;
    fork
      push_all();
    join_none
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(n_acc == 4, "R9", "words accepted when stalled", 64'(n_acc), 64'd4);
    chk(!fetch_ready, "R9", "fetch_ready when full", 64'(fetch_ready), 64'd0);
    @(posedge clk); #1;
    bp_mode = 0;
    wait fork;
    wait_done("R9");
  endtask

  task automatic t_redirect();
    bp_mode = 2; cur_req = "R6";
    build(32'h40, 1, 8);
    redirect(32'h40);
    for (int k = 0; k < 3; k++) push_word(wbuf[k]);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(insn_valid, "R6", "pending before redirect", 64'(insn_valid), 64'd1);
    @(posedge clk); #1;
    build(32'h1001, 1, 12);
    fetch_valid = 1'b1; fetch_data = 32'h0000_0000;
    redirect(32'h1001);
    fetch_valid = 1'b0;
    @(negedge clk);
    chk(!insn_valid, "R6", "output after redirect", 64'(insn_valid), 64'd0);
    @(posedge clk); #1;
    bp_mode = 0;
    push_all();
    wait_done("R6");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    run_prog(32'h100, 0, 10, 0, "R2");
    run_prog(32'h1000, 1, 24, 0, "R5");
    run_prog(32'h51, 2, 8, 0, "R7");
    run_prog(32'h407, 1, 12, 0, "R7");
    run_prog(32'h2000, 1, 24, 1, "R8");
    run_prog(32'h3000, 1, 18, 1, "R3");
    run_prog(32'h500, 1, 12, 0, "R4");
    t_latency();
    t_fill();
    t_redirect();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule